// File: doc/BRIEF.md
# Banked ROM Mapper with Overflow Interrupt Timer

This block sits on the bus of an 8-bit CPU and does two jobs. It maps CPU read addresses onto a larger program ROM through one switchable 16 KiB window and one fixed window. It also runs an up-counting interrupt timer that is driven by the CPU cycle rate. The CPU programs both through writes to the upper half of its address space. The register being written is chosen by address bits [15:12], and only the low nibble of the data byte counts.

The timer counts upward once per CPU cycle. When it passes its top value it raises a level interrupt and reloads from a latch that software fills four bits at a time. The timer has a full-width mode and a short mode. In the short mode only the low byte counts and reloads. A rearm bit sets what happens after the timer fires. With rearm set, counting carries on after the overflow. With rearm clear, counting stops until software acknowledges the interrupt, and the acknowledge then copies the rearm bit back into the enable.

Top module: `bank_irq_mapper`

## Requirements
- R1: A write with address bits [15:12] equal to 0x8, 0x9, 0xA or 0xB puts data[3:0] into reload-latch bits [3:0], [7:4], [11:8] or [15:12] respectively. All other latch bits keep their values.
- R2: A write with address bits [15:12] equal to 0xC sets three control bits: short mode from data[2] (1 = 8-bit count), enable from data[1] and rearm from data[0]. When data[1] is 1, the same write also loads the whole 16-bit counter from the latch.
- R3: A write with address bits [15:12] equal to 0xD clears the interrupt output and copies the stored rearm bit into enable.
- R4: In full mode with enable set, the counter goes up by one on each counting cycle. On the cycle where it steps past 0xFFFF, the interrupt is raised, rearm is copied into enable, and the whole counter reloads from the latch.
- R5: In short mode with enable set, only counter bits [7:0] count. On the cycle where they step past 0xFF, the interrupt is raised, rearm is copied into enable, and bits [7:0] reload from latch bits [7:0]. Counter bits [15:8] do not change.
- R6: A write with address bits [15:12] equal to 0xF stores data[3:0] as the switchable bank number.
- R7: rom_addr is {bank, cpu_addr[13:0]}. For cpu_addr below 0xC000 the bank is the stored number. For cpu_addr of 0xC000 and above it is the fixed value 15. The output follows cpu_addr and the bank combinationally.
- R8: An active-low reset clears the bank, mode, enable, rearm, latch, counter and interrupt to zero.
- R9: A write with address bits [15:12] equal to 0xE, or with cpu_addr[15] equal to 0, changes no register.
- R10: The interrupt output is a level. Once raised, it stays high through any number of further overflows until a 0xD write or a reset clears it.
- R11: The counter steps only on edges where cpu_ce is high. A write decoded as 0x8 through 0xD on the same edge takes the place of that step, so the step is lost. A bank write (0xF) does not block the step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_ce | input | 1 | High on edges that end a CPU cycle; the timer counts only on these |
| wr_en | input | 1 | CPU write strobe, sampled on every edge |
| cpu_addr | input | 16 | CPU address, used for register decode and ROM mapping |
| cpu_data | input | 8 | CPU write data |
| rom_addr | output | 18 | Translated program ROM address |
| irq | output | 1 | Level interrupt request, active high |

## Verification
The bench builds the block with its default parameters: a 4-bit bank, a 16-bit address, a 16-bit counter and an 8-bit short window. With these values a full-mode overflow is only a few steps away once the latch is loaded near 0xFFFF, and a short-mode overflow never takes more than 256 steps. Directed sequences therefore reach every wrap, every rearm choice and every clash between a write and a step within a few cycles. The random phase pushes the upper latch nibbles toward 0xF, so the full-mode timer also overflows often while register writes land at random times against the steps.

// File: rtl/mapper_pkg.sv
`timescale 1ns/1ps
package mapper_pkg;

    // register window codes decoded from the top address nibble
    localparam logic [3:0] SEL_LATCH_LO = 4'h8;  // first of the latch nibble windows
    localparam logic [3:0] SEL_CTRL     = 4'hC;
    localparam logic [3:0] SEL_ACK      = 4'hD;
    localparam logic [3:0] SEL_BANK     = 4'hF;

    localparam int LATCH_SLOTS = 4;
    localparam int SLOT_W      = $clog2(LATCH_SLOTS);

    typedef struct packed {
        logic              lat_we;
        logic [SLOT_W-1:0] lat_idx;
        logic              ctrl_we;
        logic              ack_we;
        logic              bank_we;
    } wr_strobe_t;

endpackage

// File: rtl/mapper_wr_decode.sv
`timescale 1ns/1ps
module mapper_wr_decode
    import mapper_pkg::*;
(
    input  logic       wr_en,
    input  logic [3:0] sel,
    output wr_strobe_t stb
);

    logic [3:0] slot_off;

    always_comb begin
        stb      = '0;
        slot_off = sel - SEL_LATCH_LO;
        if (wr_en) begin
            if (sel >= SEL_LATCH_LO && sel < SEL_CTRL) begin
                stb.lat_we  = 1'b1;
                stb.lat_idx = slot_off[SLOT_W-1:0];
            end
            stb.ctrl_we = (sel == SEL_CTRL);
            stb.ack_we  = (sel == SEL_ACK);
            stb.bank_we = (sel == SEL_BANK);
        end
    end

endmodule

// File: rtl/mapper_irq_timer.sv
`timescale 1ns/1ps
module mapper_irq_timer
    import mapper_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int SHORT_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpu_ce,
    input  wr_strobe_t stb,
    input  logic [3:0] wdata,
    output logic       irq
);

    localparam int NIB = CNT_W / 4;
    localparam logic [CNT_W-1:0]   CNT_ONE   = 1;
    localparam logic [SHORT_W-1:0] SHORT_ONE = 1;

    typedef struct packed {
        logic             short_mode;
        logic             en;
        logic             rearm;
        logic             irq;
        logic [CNT_W-1:0] latch;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic timer_wr;

    assign timer_wr = stb.lat_we | stb.ctrl_we | stb.ack_we;

    always_comb begin
        tmr_d = tmr_q;
        if (stb.lat_we) begin
            for (int i = 0; i < NIB; i++) begin
                if (stb.lat_idx == SLOT_W'(i)) tmr_d.latch[i*4 +: 4] = wdata;
            end
        end else if (stb.ctrl_we) begin
            tmr_d.short_mode = wdata[2];
            tmr_d.en         = wdata[1];
            tmr_d.rearm      = wdata[0];
            if (wdata[1]) tmr_d.cnt = tmr_q.latch;
        end else if (stb.ack_we) begin
            tmr_d.irq = 1'b0;
            tmr_d.en  = tmr_q.rearm;
        end else if (cpu_ce && tmr_q.en) begin
            if (!tmr_q.short_mode) begin
                if (&tmr_q.cnt) begin
                    tmr_d.irq = 1'b1;
                    tmr_d.en  = tmr_q.rearm;
                    tmr_d.cnt = tmr_q.latch;
                end else begin
                    tmr_d.cnt = tmr_q.cnt + CNT_ONE;
                end
            end else begin
                if (&tmr_q.cnt[SHORT_W-1:0]) begin
                    tmr_d.irq                = 1'b1;
                    tmr_d.en                 = tmr_q.rearm;
                    tmr_d.cnt[SHORT_W-1:0]   = tmr_q.latch[SHORT_W-1:0];
                end else begin
                    tmr_d.cnt[SHORT_W-1:0]   = tmr_q.cnt[SHORT_W-1:0] + SHORT_ONE;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign irq = tmr_q.irq;

    // R3: acknowledge drops the request on the next edge
    assert_ack_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stb.ack_we |=> !tmr_q.irq);

    // R10: request is held until acknowledged
    assert_irq_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.irq && !stb.ack_we) |=> tmr_q.irq);

    // R11: no counting cycle and no reload means the counter holds
    assert_hold_no_ce_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_ce && !stb.ctrl_we) |=> $stable(tmr_q.cnt));

    // R4: a rising request follows an enabled counting cycle with no register write
    assert_irq_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmr_q.irq) |-> $past(cpu_ce && tmr_q.en && !timer_wr));

    // R5: upper counter bits stay put in short mode
    assert_short_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.short_mode && !stb.ctrl_we) |=> $stable(tmr_q.cnt[CNT_W-1:SHORT_W]));

endmodule

// File: rtl/mapper_rom_xlate.sv
`timescale 1ns/1ps
module mapper_rom_xlate #(
    parameter int ADDR_W = 16,
    parameter int BANK_W = 4,
    localparam int PAGE_W = ADDR_W - 2,
    localparam int ROM_W  = BANK_W + PAGE_W
) (
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [BANK_W-1:0] bank,
    output logic [ROM_W-1:0]  rom_addr
);

    logic              fixed_win;
    logic [BANK_W-1:0] eff_bank;

    always_comb begin
        fixed_win = &cpu_addr[ADDR_W-1 -: 2];
        eff_bank  = fixed_win ? {BANK_W{1'b1}} : bank;
        rom_addr  = {eff_bank, cpu_addr[PAGE_W-1:0]};
    end

endmodule

// File: rtl/bank_irq_mapper.sv
`timescale 1ns/1ps
module bank_irq_mapper
    import mapper_pkg::*;
#(
    parameter int BANK_W  = 4,
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int CNT_W   = 16,
    parameter int SHORT_W = 8,
    localparam int ROM_W  = BANK_W + ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_ce,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_data,
    output logic [ROM_W-1:0]  rom_addr,
    output logic              irq
);

    wr_strobe_t        stb;
    logic [BANK_W-1:0] bank_d, bank_q;
    logic              unused_hi;

    assign unused_hi = ^cpu_data[DATA_W-1:4];

    mapper_wr_decode u_dec (
        .wr_en (wr_en),
        .sel   (cpu_addr[ADDR_W-1 -: 4]),
        .stb   (stb)
    );

    mapper_irq_timer #(
        .CNT_W   (CNT_W),
        .SHORT_W (SHORT_W)
    ) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .cpu_ce (cpu_ce),
        .stb    (stb),
        .wdata  (cpu_data[3:0]),
        .irq    (irq)
    );

    always_comb begin
        bank_d = bank_q;
        if (stb.bank_we) bank_d = cpu_data[BANK_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    mapper_rom_xlate #(
        .ADDR_W (ADDR_W),
        .BANK_W (BANK_W)
    ) u_xlate (
        .cpu_addr (cpu_addr),
        .bank     (bank_q),
        .rom_addr (rom_addr)
    );

    // R7: upper quarter of the CPU space always lands in the last bank
    always_comb begin
        if (rst_n && (&cpu_addr[ADDR_W-1 -: 2])) begin
            assert_fixed_bank_R7: assert (&rom_addr[ROM_W-1 -: BANK_W]);
        end
    end

    // R6: bank write takes the written value
    assert_bank_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cpu_addr[ADDR_W-1 -: 4] == SEL_BANK)
        |=> bank_q == $past(cpu_data[BANK_W-1:0]));

    // R9: spare window and lower half leave the bank alone
    assert_ignored_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (cpu_addr[ADDR_W-1 -: 4] == 4'hE || !cpu_addr[ADDR_W-1]))
        |=> $stable(bank_q));

endmodule

// File: tb/bank_irq_mapper_tb.sv
`timescale 1ns/1ps
module bank_irq_mapper_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_ce = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_data = 8'h00;
    logic [17:0] rom_addr;
    logic        irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    bank_irq_mapper #(
        .BANK_W (4), .ADDR_W (16), .DATA_W (8), .CNT_W (16), .SHORT_W (8)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .cpu_ce (cpu_ce), .wr_en (wr_en),
        .cpu_addr (cpu_addr), .cpu_data (cpu_data),
        .rom_addr (rom_addr), .irq (irq)
    );

    typedef struct {
        logic [3:0]  bank;
        logic        short_mode, en, rearm, irq;
        logic [15:0] latch, cnt;
    } mdl_t;

    mdl_t m;

    function automatic mdl_t mdl_clear();
        mdl_t z;
        z.bank = 0; z.short_mode = 0; z.en = 0; z.rearm = 0; z.irq = 0;
        z.latch = 0; z.cnt = 0;
        return z;
    endfunction

    function automatic mdl_t mdl_next(mdl_t s, logic ce, logic we,
                                      logic [15:0] a, logic [7:0] d);
        mdl_t n = s;
        logic [3:0] region = a[15:12];
        logic blocks_step = we && (region >= 4'h8) && (region <= 4'hD);
        if (we) begin
            case (region)
                4'h8: n.latch[3:0]   = d[3:0];
                4'h9: n.latch[7:4]   = d[3:0];
                4'hA: n.latch[11:8]  = d[3:0];
                4'hB: n.latch[15:12] = d[3:0];
                4'hC: begin
                    n.short_mode = d[2]; n.en = d[1]; n.rearm = d[0];
                    if (d[1]) n.cnt = s.latch;
                end
                4'hD: begin n.irq = 1'b0; n.en = s.rearm; end
                4'hF: n.bank = d[3:0];
                default: ;
            endcase
        end
        if (!blocks_step && ce && s.en) begin
            if (s.short_mode) begin
                if (s.cnt[7:0] == 8'hFF) begin
                    n.irq = 1'b1; n.en = s.rearm; n.cnt[7:0] = s.latch[7:0];
                end else n.cnt[7:0] = s.cnt[7:0] + 8'd1;
            end else begin
                if (s.cnt == 16'hFFFF) begin
                    n.irq = 1'b1; n.en = s.rearm; n.cnt = s.latch;
                end else n.cnt = s.cnt + 16'd1;
            end
        end
        return n;
    endfunction

    function automatic logic [17:0] want_rom(logic [15:0] a, logic [3:0] b);
        return (a >= 16'hC000) ? {4'hF, a[13:0]} : {b, a[13:0]};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(logic ce, logic we, logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        cpu_ce = ce; wr_en = we; cpu_addr = a; cpu_data = d;
        #1;
        chk("R7 rom_addr vs model", rom_addr, want_rom(a, m.bank));
        m = mdl_next(m, ce, we, a, d);
        @(posedge clk);
        #2;
        chk("R4/R5 irq vs model", irq, m.irq);
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] d);
        cyc(1'b0, 1'b1, a, d);
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 16'h8123, 8'h00);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 16'h4567, 8'h00);
    endtask

    task automatic peek_rom(logic [15:0] a, logic [17:0] exp, string tag);
        @(negedge clk);
        cpu_ce = 0; wr_en = 0; cpu_addr = a;
        #1;
        chk(tag, rom_addr, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        m = mdl_clear();
        repeat (3) @(posedge clk);
        #2;
        chk("R8 irq low in reset", irq, 0);
        @(negedge clk);
        rst_n = 1'b1;
        peek_rom(16'h8123, 18'h00123, "R8 bank zero after reset");
        peek_rom(16'hC456, 18'h3C456, "R7 fixed window after reset");

        // R6 bank select and R7 window edges
        wr(16'hF000, 8'hA5);
        peek_rom(16'h9ABC, 18'h15ABC, "R6 bank 5 from low nibble");
        peek_rom(16'hBFFF, 18'h17FFF, "R7 last switchable address");
        peek_rom(16'hC000, 18'h3C000, "R7 first fixed address");
        peek_rom(16'hFFFF, 18'h3FFFF, "R7 top address");

        // R1/R2/R4 full mode, latch 0xFFFD, no rearm
        wr(16'h8000, 8'hFD); wr(16'h9000, 8'h0F);
        wr(16'hA000, 8'hEF); wr(16'hB000, 8'h0F);
        wr(16'hC000, 8'h02);
        idle(5);
        chk("R11 no count without cpu_ce", irq, 0);
        step(2);
        chk("R1 counter at 0xFFFF not yet wrapped", irq, 0);
        step(1);
        chk("R4 full-mode wrap raises irq", irq, 1);
        step(300);
        chk("R10 irq held while stopped", irq, 1);
        wr(16'hD000, 8'h00);
        chk("R3 ack clears irq", irq, 0);
        step(5);
        chk("R3 ack copies rearm=0 to enable", irq, 0);

        // R5 short mode with rearm, latch low byte 0xFE
        wr(16'h8000, 8'h0E);
        wr(16'hC000, 8'h07);
        step(1);
        chk("R5 low byte at 0xFF", irq, 0);
        step(1);
        chk("R5 short wrap raises irq", irq, 1);
        wr(16'hD000, 8'h00);
        chk("R3 ack clears irq again", irq, 0);
        step(1);
        chk("R5 reload from latch low byte", irq, 0);
        step(1);
        chk("R5 rearm keeps counting", irq, 1);
        step(10);
        chk("R10 irq level across wraps", irq, 1);
        wr(16'hD000, 8'h00);
        wr(16'hC000, 8'h00);

        // R11 write/step clash
        wr(16'hC000, 8'h02);
        step(1);
        cyc(1'b1, 1'b1, 16'h8000, 8'h0E);
        chk("R11 latch write blocks step", irq, 0);
        cyc(1'b1, 1'b1, 16'hF000, 8'h03);
        chk("R11 bank write does not block step", irq, 1);
        peek_rom(16'h4123, 18'h0C123, "R6 bank 3 selected");
        wr(16'hD000, 8'h00);

        // R9 ignored windows
        wr(16'hE000, 8'h06);
        wr(16'h7000, 8'h06);
        wr(16'h1000, 8'h0A);
        step(4);
        chk("R9 ignored writes start no timer", irq, 0);
        peek_rom(16'h8000, 18'h0C000, "R9 ignored writes keep bank");

        // random phase against the model
        for (int n = 0; n < 20000; n++) begin
            logic        ce = ($urandom % 4) != 0;
            logic        we = ($urandom % 16) == 0;
            logic [3:0]  rg = 4'($urandom % 16);
            logic [7:0]  dv = 8'($urandom);
            logic [15:0] ad = {rg, 12'($urandom)};
            if (we && (rg == 4'h9 || rg == 4'hA || rg == 4'hB) && ($urandom % 4 != 0))
                dv[3:0] = 4'hF;
            if (we && rg == 4'hC && ($urandom % 3 != 0)) dv[1] = 1'b1;
            if (!we) ad = 16'($urandom);
            cyc(ce, we, ad, dv);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule